// File: doc/BRIEF.md
# OFDM Subcarrier Mapper (64/256 bins)

This block takes a stream of complex constellation points and assembles one frequency-domain OFDM symbol for a downstream IFFT. A one-bit layout select chooses a 64-bin layout or a 256-bin layout. Each layout has its own pilot positions and its own null bins (the band edges and DC), so one symbol holds 48 data points in the small layout and 192 in the large one.

Data points are taken in on a valid/ready stream and stored in ascending logical-subcarrier order, starting from the most negative index. Once a full set has arrived, the block emits every bin of the symbol on a valid/last stream in IFFT address order. Logical subcarrier k appears at address k mod N, so the non-negative half is emitted first and the negative half after it. Pilot bins carry a fixed real amplitude with a per-position sign. Null bins carry zero. While the symbol is being emitted the input is held off.

Top module: `ofdm_subcarrier_mapper`

## Requirements
- R1: During reset and right after it, out_valid and out_last are 0 and in_ready is 1. A reset in the middle of filling drops the partial symbol.
- R2: With std_sel=0, a symbol is 64 bins. Address a holds logical k = a for a < 32 and k = a-64 otherwise. Bins k in -32..-27, k = 0 and k in 27..31 are null. Pilots sit at k = -21, -7, 7 and 21.
- R3: With std_sel=1, a symbol is 256 bins. Address a holds logical k = a for a < 128 and k = a-256 otherwise. Bins k in -128..-101, k = 0 and k in 101..127 are null. Pilots sit at k = -88, -63, -38, -13, 13, 38, 63 and 88.
- R4: A symbol takes exactly 48 data points in the 64-bin layout and 192 in the 256-bin layout. The n-th accepted point (from 0) lands on the n-th data bin counted in ascending logical index, and it appears unchanged on out_i/out_q.
- R5: A pilot bin outputs I = +PILOT_MAG (8192 by default) and Q = 0. The exceptions are k = +21 (64-bin) and k = +63, +88 (256-bin), which output I = -PILOT_MAG. A null bin outputs I = Q = 0.
- R6: std_sel is sampled when the first data point of a symbol is accepted. Changes to it later in the same symbol have no effect on the layout.
- R7: out_valid rises the cycle after the final data point is accepted and stays high for exactly N consecutive cycles. out_last is high only on the last of those cycles, and out_valid is low in the cycle after it.
- R8: in_ready is low from the acceptance of the final data point until the final bin is presented. A data point held valid during that time is not consumed.
- R9: Idle cycles on in_valid while a symbol is filling stall the fill and do not change the order in which points are placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel | input | 1 | Layout select: 0 = 64 bins, 1 = 256 bins |
| in_valid | input | 1 | Input point valid |
| in_ready | output | 1 | Mapper can accept a point |
| in_i | input | SAMPLE_W | In-phase part of input point, signed |
| in_q | input | SAMPLE_W | Quadrature part of input point, signed |
| out_valid | output | 1 | Output bin valid |
| out_last | output | 1 | Final bin of the symbol |
| out_i | output | SAMPLE_W | In-phase part of output bin |
| out_q | output | SAMPLE_W | Quadrature part of output bin |

## Verification
The hardest case to reach is a layout change that arrives partway through filling a symbol. This matters because the block decides the point count from std_sel only at the first accepted point. The stimulus table has entries that flip std_sel one point into the fill and hold the flipped value until the symbol has been emitted. The bench then expects the originally chosen layout bin for bin. A second hard case is a point held valid during the whole emission window, which exposes any early ready. The bench keeps in_valid high with stale data across each emission, so a leak shifts every data bin of the following symbol.

// File: rtl/ofdm_map_pkg.sv
package ofdm_map_pkg;

   typedef enum logic {
      STD_N64  = 1'b0,
      STD_N256 = 1'b1
   } std_e;

   typedef enum logic [1:0] {
      BIN_NULL  = 2'd0,
      BIN_PILOT = 2'd1,
      BIN_DATA  = 2'd2
   } bin_e;

   typedef struct packed {
      bin_e kind;
      logic neg;
   } bin_cls_t;

   localparam int unsigned NB_SMALL   = 64;
   localparam int unsigned NB_LARGE   = 256;
   localparam int unsigned ND_SMALL   = 48;
   localparam int unsigned ND_LARGE   = 192;
   localparam int unsigned NEG_SMALL  = 24;
   localparam int unsigned NEG_LARGE  = 96;
   localparam int unsigned EDGE_SMALL = 27;
   localparam int unsigned EDGE_LARGE = 101;

endpackage

// File: rtl/ofdm_bin_classifier.sv
module ofdm_bin_classifier
   import ofdm_map_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  std_e             mode,
   input  logic [ADDR_W-1:0] addr,
   output bin_cls_t         cls
);

   always_comb begin
      int n;
      int a;
      int k;
      int edge_lo;
      n       = (mode == STD_N256) ? int'(NB_LARGE)   : int'(NB_SMALL);
      edge_lo = (mode == STD_N256) ? int'(EDGE_LARGE) : int'(EDGE_SMALL);
      a       = int'(addr);
      k       = (a < n / 2) ? a : a - n;
      cls.kind = BIN_DATA;
      cls.neg  = 1'b0;
      if (k == 0 || k >= edge_lo || k <= -edge_lo) begin
         cls.kind = BIN_NULL;
      end else if (mode == STD_N256) begin
         if (k == 13 || k == -13 || k == 38 || k == -38 ||
             k == 63 || k == -63 || k == 88 || k == -88) begin
            cls.kind = BIN_PILOT;
            cls.neg  = (k == 63) || (k == 88);
         end
      end else begin
         if (k == 7 || k == -7 || k == 21 || k == -21) begin
            cls.kind = BIN_PILOT;
            cls.neg  = (k == 21);
         end
      end
   end

endmodule

// File: rtl/ofdm_sym_buffer.sv
module ofdm_sym_buffer #(
   parameter int W     = 16,
   parameter int DEPTH = 192,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_i,
   input  logic [W-1:0]     wr_q,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_i,
   output logic [W-1:0]     rd_q
);

   localparam logic [IDX_W:0] DEPTH_V = (IDX_W + 1)'(DEPTH);

   logic [1:0][W-1:0] wr_lane;
   logic [1:0][W-1:0] rd_lane;
   logic              wr_ok;
   logic              rd_ok;

   assign wr_lane[0] = wr_i;
   assign wr_lane[1] = wr_q;
   assign wr_ok      = ({1'b0, wr_idx} < DEPTH_V);
   assign rd_ok      = ({1'b0, rd_idx} < DEPTH_V);

   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_ok) begin
            mem[wr_idx] <= wr_lane[l];
         end
      end

      assign rd_lane[l] = rd_ok ? mem[rd_idx] : '0;
   end

   assign rd_i = rd_lane[0];
   assign rd_q = rd_lane[1];

endmodule

// File: rtl/ofdm_map_ctrl.sv
module ofdm_map_ctrl
   import ofdm_map_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              std_sel,
   input  logic              in_valid,
   input  bin_e              bin_kind,
   output logic              in_ready,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              emit,
   output logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  rd_idx,
   output std_e              sym_mode,
   output logic              bin_last
);

   typedef enum logic {ST_FILL, ST_EMIT} st_e;

   st_e               state;
   std_e              mode_q;
   std_e              cur_mode;
   logic [IDX_W-1:0]  wr_cnt;
   logic [IDX_W-1:0]  ord;
   logic [IDX_W-1:0]  dcnt_m1;
   logic [IDX_W-1:0]  neg_cnt;
   logic [ADDR_W-1:0] last_addr;
   logic [ADDR_W-1:0] half_m1;

   // the layout is taken from the pin only for the first point of a symbol
   assign cur_mode = (state == ST_FILL && wr_cnt == '0) ? std_e'(std_sel) : mode_q;

   always_comb begin
      if (cur_mode == STD_N256) begin
         dcnt_m1   = IDX_W'(ND_LARGE - 1);
         neg_cnt   = IDX_W'(NEG_LARGE);
         last_addr = ADDR_W'(NB_LARGE - 1);
         half_m1   = ADDR_W'(NB_LARGE / 2 - 1);
      end else begin
         dcnt_m1   = IDX_W'(ND_SMALL - 1);
         neg_cnt   = IDX_W'(NEG_SMALL);
         last_addr = ADDR_W'(NB_SMALL - 1);
         half_m1   = ADDR_W'(NB_SMALL / 2 - 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_FILL;
         mode_q <= STD_N64;
         wr_cnt <= '0;
         addr   <= '0;
         ord    <= '0;
      end else begin
         case (state)
            ST_FILL: begin
               if (in_valid) begin
                  if (wr_cnt == '0) begin
                     mode_q <= cur_mode;
                  end
                  if (wr_cnt == dcnt_m1) begin
                     state  <= ST_EMIT;
                     wr_cnt <= '0;
                     addr   <= '0;
                     // positive half comes first: its data begins after the negative-half data
                     ord    <= neg_cnt;
                  end else begin
                     wr_cnt <= wr_cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (addr == last_addr) begin
                  state <= ST_FILL;
                  addr  <= '0;
               end else begin
                  addr <= addr + 1'b1;
               end
               if (addr == half_m1) begin
                  ord <= '0;
               end else if (bin_kind == BIN_DATA) begin
                  ord <= ord + 1'b1;
               end
            end
         endcase
      end
   end

   assign in_ready = (state == ST_FILL);
   assign wr_en    = in_valid && (state == ST_FILL);
   assign wr_idx   = wr_cnt;
   assign emit     = (state == ST_EMIT);
   assign rd_idx   = ord;
   assign sym_mode = mode_q;
   assign bin_last = (addr == last_addr);

endmodule

// File: rtl/ofdm_subcarrier_mapper.sv
module ofdm_subcarrier_mapper
   import ofdm_map_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int PILOT_MAG = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                std_sel,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   output logic                out_valid,
   output logic                out_last,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q
);

   localparam int ADDR_W = $clog2(NB_LARGE);
   localparam int IDX_W  = $clog2(ND_LARGE);
   localparam logic [SAMPLE_W-1:0] P_POS = SAMPLE_W'(PILOT_MAG);
   localparam logic [SAMPLE_W-1:0] P_NEG = SAMPLE_W'(-PILOT_MAG);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("SAMPLE_W must be at least 2");
   end
   if (PILOT_MAG <= 0 || PILOT_MAG >= (1 << (SAMPLE_W - 1))) begin : g_bad_mag
      $error("PILOT_MAG must fit a positive signed sample");
   end

   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic [ADDR_W-1:0] addr;
   logic              emit;
   logic              bin_last;
   std_e              sym_mode;
   bin_cls_t          cls;
   logic [SAMPLE_W-1:0] rd_i;
   logic [SAMPLE_W-1:0] rd_q;

   ofdm_map_ctrl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .std_sel  (std_sel),
      .in_valid (in_valid),
      .bin_kind (cls.kind),
      .in_ready (in_ready),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .emit     (emit),
      .addr     (addr),
      .rd_idx   (rd_idx),
      .sym_mode (sym_mode),
      .bin_last (bin_last)
   );

   ofdm_bin_classifier #(
      .ADDR_W (ADDR_W)
   ) u_cls (
      .mode (sym_mode),
      .addr (addr),
      .cls  (cls)
   );

   ofdm_sym_buffer #(
      .W     (SAMPLE_W),
      .DEPTH (ND_LARGE),
      .IDX_W (IDX_W)
   ) u_buf (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_i   (in_i),
      .wr_q   (in_q),
      .rd_idx (rd_idx),
      .rd_i   (rd_i),
      .rd_q   (rd_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= emit;
         out_last  <= emit && bin_last;
         if (!emit) begin
            out_i <= '0;
            out_q <= '0;
         end else begin
            case (cls.kind)
               BIN_DATA: begin
                  out_i <= rd_i;
                  out_q <= rd_q;
               end
               BIN_PILOT: begin
                  out_i <= cls.neg ? P_NEG : P_POS;
                  out_q <= '0;
               end
               default: begin
                  out_i <= '0;
                  out_q <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/ofdm_subcarrier_mapper_chk.sv
module ofdm_subcarrier_mapper_chk (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic out_valid,
   input logic out_last,
   input logic sym_mode
);

   // R8
   ready_low_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);

   // R7
   last_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R7
   last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> !out_valid);

   // R7
   valid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> $stable(sym_mode));

endmodule

bind ofdm_subcarrier_mapper ofdm_subcarrier_mapper_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_last  (out_last),
   .sym_mode  (sym_mode)
);

// File: tb/ofdm_subcarrier_mapper_bench.sv
`timescale 1ns/1ps
module ofdm_subcarrier_mapper_bench;

   localparam int W   = 16;
   localparam int MAG = 8192;

   // fields: [10] idle gaps, [9] flip select mid-fill, [8] layout, [7:0] seed
   localparam logic [10:0] VEC_TBL [0:6] = '{
      {1'b0, 1'b0, 1'b0, 8'h11},
      {1'b0, 1'b0, 1'b1, 8'h22},
      {1'b0, 1'b0, 1'b0, 8'h33},
      {1'b0, 1'b1, 1'b0, 8'h44},
      {1'b0, 1'b1, 1'b1, 8'h55},
      {1'b1, 1'b0, 1'b1, 8'h66},
      {1'b1, 1'b0, 1'b0, 8'h77}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         std_sel = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] in_i = '0;
   logic [W-1:0] in_q = '0;
   logic         out_valid;
   logic         out_last;
   logic [W-1:0] out_i;
   logic [W-1:0] out_q;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ofdm_subcarrier_mapper u_ofdm_subcarrier_mapper (
      .clk       (clk),
      .rst_n     (rst_n),
      .std_sel   (std_sel),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // 0 null, 1 pilot, 2 data
   function automatic int kind_of(bit m, int k);
      if (m) begin
         if (k == 0 || k <= -101 || k >= 101) return 0;
         if (k == 13 || k == -13 || k == 38 || k == -38 || k == 63 || k == -63 ||
             k == 88 || k == -88) return 1;
      end else begin
         if (k == 0 || k <= -27 || k >= 27) return 0;
         if (k == 7 || k == -7 || k == 21 || k == -21) return 1;
      end
      return 2;
   endfunction

   function automatic int ordinal_of(bit m, int k);
      int n = m ? 256 : 64;
      int c = 0;
      for (int j = -n / 2; j < k; j++) begin
         if (kind_of(m, j) == 2) c++;
      end
      return c;
   endfunction

   task automatic run_symbol(input bit m, input bit flip, input bit gap, input logic [7:0] seed);
      int n  = m ? 256 : 64;
      int nd = m ? 192 : 48;
      std_sel = m;
      for (int j = 0; j < nd; j++) begin
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         if (gap && (j % 5) == 3) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_i = {seed, 8'(j)};
         in_q = ~{seed, 8'(j)};
         if (flip && j == 1) std_sel = ~m;
      end
      // the final point is accepted at the next edge; in_valid stays high with stale data
      @(negedge clk);
      check(out_valid == 1'b0, "R7", int'(out_valid), 0);
      check(in_ready == 1'b0, "R8", int'(in_ready), 0);
      @(negedge clk);
      for (int a = 0; a < n; a++) begin
         int k = (a < n / 2) ? a : a - n;
         int kd = kind_of(m, k);
         logic [W-1:0] ei;
         logic [W-1:0] eq;
         string req;
         if (kd == 2) begin
            ei = {seed, 8'(ordinal_of(m, k))};
            eq = ~ei;
            req = "R4";
         end else if (kd == 1) begin
            ei = ((!m && k == 21) || (m && (k == 63 || k == 88))) ? W'(-MAG) : W'(MAG);
            eq = '0;
            req = "R5";
         end else begin
            ei = '0;
            eq = '0;
            req = "R5";
         end
         if (flip) req = "R6";
         else if (gap) req = "R9";
         check(out_valid == 1'b1, "R7", int'(out_valid), 1);
         check(out_last == (a == n - 1), m ? "R3" : "R2", int'(out_last), int'(a == n - 1));
         check(out_i == ei, req, int'(out_i), int'(ei));
         check(out_q == eq, req, int'(out_q), int'(eq));
         if (a < n - 1) check(in_ready == 1'b0, "R8", int'(in_ready), 0);
         else in_valid = 1'b0;
         @(negedge clk);
      end
      check(out_valid == 1'b0, "R7", int'(out_valid), 0);
      std_sel = m;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 values during reset
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
      check(out_last == 1'b0, "R1", int'(out_last), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);

      for (int v = 0; v < 7; v++) begin
         run_symbol(VEC_TBL[v][8], VEC_TBL[v][9], VEC_TBL[v][10], VEC_TBL[v][7:0]);
      end

      // R1: reset part way through a fill; the next symbol must start clean
      std_sel = 1'b0;
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_i = 16'hdead;
         in_q = 16'hbeef;
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
      run_symbol(1'b1, 1'b0, 1'b0, 8'h5a);
      run_symbol(1'b0, 1'b0, 1'b0, 8'h3c);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule